// File: doc/BRIEF.md
# Synchronous Burst Static RAM Front End

This block is the clocked control front end of a 36-bit-wide burst static RAM. A small internal array, sized by a parameter, makes the block self-contained. On each rising clock edge it registers the address, two active-low address strobes, an advance input, three chip enables, the write controls and the write data. Either strobe starts a new access at the presented address. A processor strobe always gives a read cycle. A controller strobe gives a read or a write, depending on the write controls. After a load, the advance input steps a two-bit burst counter through the four words of the aligned group, in linear or interleaved order. A static order input picks the order.

Read data comes out of a register and belongs to the address that was registered at the previous rising edge. The data bus is split into a write-data input, a read-data output and a drive flag. The drive flag stands in for a real bidirectional pin. An asynchronous output-enable input gates the drive flag. Right after the device has been deselected, the first read cycle is kept off the bus. A sleep input freezes every control register and ignores all operations, and the stored words are kept.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After synchronous reset the device is deselected and `rdata_en` is 0 with `rdata` all zero.
- R2: A strobe (either one) with all chip enables active loads the address. The word at that address appears on `rdata` with `rdata_en` = 1 right after that same edge, provided the cycle is not a write.
- R3: When both strobes are low, the processor strobe wins and the cycle is a read: the write controls and `wdata` are ignored. The processor strobe is ignored while `sel1_n` is high.
- R4: The chip enables (`sel1_n` low, `sel2` high, `sel3_n` low) are evaluated only on an edge that loads an address. A load with any enable inactive deselects the device: no write, no output. Cycles without a strobe leave that choice unchanged.
- R5: With `order_ileave` = 0, each edge with `adv_n` low, no strobe and the device selected moves to the next word. The low two address bits count up by one modulo 4, and the upper bits are kept. A start at 1 gives 1, 2, 3, 0.
- R6: With `order_ileave` = 1, the low two bits are the start bits XOR a 0..3 step count. A start at 1 gives 1, 0, 3, 2.
- R7: `wr_all_n` low on a controller-strobe or continuation edge writes all 36 bits, whatever the values of `wr_byte_en_n` and `lane_sel_n`.
- R8: When `wr_all_n` is high, a write happens only if `wr_byte_en_n` is low. Bit i of `lane_sel_n`, when low, writes data bits [9i+8:9i]. The other lanes keep their contents.
- R9: `oe_n` high forces `rdata_en` to 0 and `rdata` to zero without waiting for a clock edge. `oe_n` low lets a valid read drive.
- R10: The first read cycle after a deselected state is not driven, even with `oe_n` low. The next read cycle is driven.
- R11: While `sleep` is high, loads, writes and advances are ignored, `rdata_en` is 0, and the stored words and the current address are kept.
- R12: An edge with no strobe and `adv_n` high keeps the current address. The same word is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, read-only |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| wr_all_n | input | 1 | Full-word write, active low |
| wr_byte_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep; freezes state, keeps contents |
| order_ileave | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en | output | 1 | Read data is being driven |

## Verification
If the burst counter or the start register is wrong, the wrong word comes out on the very next driven read. The bench therefore checks every burst step against a model array and does not only check the end of a burst. If the select flag or the first-read mask is wrong, `rdata_en` has the wrong level right after the edge, so the bench checks the drive flag on each cycle around a deselect and around sleep. A bad lane mask or a write that is not suppressed leaves no mark until a later read. For that reason each suppressed or partial write is followed by an explicit read-back of the word it could have changed.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_CTL  = 2'd2
    } load_src_e;

    typedef struct packed {
        logic valid;
        logic first;
    } rd_flags_t;

    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               ileave
    );
        return ileave ? (start ^ step) : (start + step);
    endfunction

    function automatic logic chip_on(input logic e1_n, input logic e2, input logic e3_n);
        return !e1_n && e2 && !e3_n;
    endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              order_ileave,
    output load_src_e         src,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              sel_now,
    output logic              sel_next
);

    logic [ADDR_W-1:0]  start_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] step_nx;
    logic [ADDR_W-1:0]  cur_q;
    logic               sel_q;
    logic               is_load;

    always_comb begin
        if (!strobe_cpu_n && !sel1_n)
            src = SRC_CPU;
        else if (!strobe_ctl_n)
            src = SRC_CTL;
        else
            src = SRC_NONE;
    end

    assign is_load  = (src != SRC_NONE);
    assign step_nx  = (sel_q && !adv_n) ? step_q + 1'b1 : step_q;
    assign sel_next = is_load ? chip_on(sel1_n, sel2, sel3_n) : sel_q;
    assign sel_now  = sel_q;

    always_comb begin
        if (is_load)
            eff_addr = addr;
        else
            eff_addr = {start_q[ADDR_W-1:BURST_W],
                        burst_lo(start_q[BURST_W-1:0], step_nx, order_ileave)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            start_q <= '0;
            step_q  <= '0;
            cur_q   <= '0;
        end else if (!sleep) begin
            sel_q <= sel_next;
            cur_q <= eff_addr;
            if (is_load) begin
                start_q <= addr;
                step_q  <= '0;
            end else begin
                step_q  <= step_nx;
            end
        end
    end

    // R5: a linear advance moves the low bits up by one
    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !sleep && strobe_cpu_n && strobe_ctl_n && !adv_n && !order_ileave)
        |=> (cur_q[BURST_W-1:0] == $past(cur_q[BURST_W-1:0]) + 2'd1)
            && (cur_q[ADDR_W-1:BURST_W] == $past(cur_q[ADDR_W-1:BURST_W])));

    // R11: sleep freezes the control state
    a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(sel_q) && $stable(cur_q) && $stable(step_q) && $stable(start_q));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_we[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)
                rdata[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end

endmodule

// File: rtl/bsram_out.sv
module bsram_out
    import bsram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  rd_flags_t         flags_d,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] data_q,
    output logic              rdata_en,
    output logic [DATA_W-1:0] rdata
);

    rd_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (sleep)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign rdata_en = !oe_n && flags_q.valid && !flags_q.first;
    assign rdata    = rdata_en ? data_q : '0;

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    adv_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    order_ileave,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);

    localparam int DATA_W = LANES * LANE_W;

    load_src_e         src;
    logic [ADDR_W-1:0] eff_addr;
    logic              sel_now;
    logic              sel_next;
    logic [LANES-1:0]  lane_we;
    logic              wr_en;
    rd_flags_t         flags_d;
    logic [DATA_W-1:0] arr_q;

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .sleep        (sleep),
        .addr         (addr),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .sel1_n       (sel1_n),
        .sel2         (sel2),
        .sel3_n       (sel3_n),
        .order_ileave (order_ileave),
        .src          (src),
        .eff_addr     (eff_addr),
        .sel_now      (sel_now),
        .sel_next     (sel_next)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_we
        assign lane_we[g] = !wr_all_n || (!wr_byte_en_n && !lane_sel_n[g]);
    end

    assign wr_en = !sleep && sel_next && (src != SRC_CPU) && (|lane_we);

    always_comb begin
        flags_d.valid = sel_next && !wr_en;
        flags_d.first = sel_next && !wr_en && !sel_now;
    end

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .wr_en   (wr_en),
        .lane_we (lane_we),
        .rd_en   (!sleep),
        .addr    (eff_addr),
        .wdata   (wdata),
        .rdata   (arr_q)
    );

    bsram_out #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .flags_d  (flags_d),
        .oe_n     (oe_n),
        .data_q   (arr_q),
        .rdata_en (rdata_en),
        .rdata    (rdata)
    );

    // R3: an accepted processor strobe never writes
    a_r3_cpu_no_write: assert property (@(posedge clk) disable iff (rst)
        (!strobe_cpu_n && !sel1_n) |-> !wr_en);

    // R4: a deselected device with no new load never writes
    a_r4_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sel_now && strobe_ctl_n && (strobe_cpu_n || sel1_n)) |-> !wr_en);

    // R10: the first read after deselect is not driven
    a_r10_first_masked: assert property (@(posedge clk) disable iff (rst)
        (!sel_now && !sleep && (src != SRC_NONE) && sel_next && !wr_en) |=> !rdata_en);

endmodule

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;

    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          strobe_cpu_n, strobe_ctl_n, adv_n;
    logic          sel1_n, sel2, sel3_n;
    logic          wr_all_n, wr_byte_en_n;
    logic [3:0]    lane_sel_n;
    logic [DW-1:0] wdata;
    logic          oe_n, sleep, order_ileave;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_mem [64];

    always #4 clk = ~clk;

    burst_sram_ctrl u_dut (
        .clk(clk), .rst(rst), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_sel_n(lane_sel_n),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .order_ileave(order_ileave),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return 36'h5A5000000 ^ (DW'(a) * 36'h010101);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
        sel1_n = 0; sel2 = 1; sel3_n = 0;
        wr_all_n = 1; wr_byte_en_n = 1; lane_sel_n = 4'hF;
        wdata = '0; oe_n = 0; sleep = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ctl_write(input int a, input logic [DW-1:0] d);
        addr = AW'(a); strobe_ctl_n = 0; wr_all_n = 0; wdata = d;
        step();
        exp_mem[a] = d;
        idle_in();
    endtask

    task automatic ctl_read(input int a);
        addr = AW'(a); strobe_ctl_n = 0;
        step();
        idle_in();
    endtask

    task automatic read_ok(input string req, input int a);
        check(req, {35'd0, rdata_en}, 36'd1);
        check(req, rdata, exp_mem[a]);
    endtask

    task automatic t_reset();
        idle_in(); order_ileave = 0; addr = '0; rst = 1;
        repeat (3) step();
        rst = 0;
        check("R1 drive after reset", {35'd0, rdata_en}, 36'd0);
        check("R1 data after reset", rdata, 36'd0);
    endtask

    task automatic t_basic();
        for (int a = 8; a < 14; a++) ctl_write(a, pat(a));
        ctl_read(10);
        read_ok("R2 controller strobe read", 10);
        addr = AW'(11); strobe_cpu_n = 0;
        step(); idle_in();
        read_ok("R2 processor strobe read", 11);
    endtask

    task automatic t_linear();
        order_ileave = 0;
        ctl_read(9);
        read_ok("R5 start", 9);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 0; step(); idle_in();
            read_ok("R5 linear step", 8 + ((1 + k) % 4));
        end
    endtask

    task automatic t_ileave();
        int seq [4] = '{9, 8, 11, 10};
        order_ileave = 1;
        ctl_read(9);
        read_ok("R6 start", 9);
        for (int k = 1; k < 4; k++) begin
            adv_n = 0; step(); idle_in();
            read_ok("R6 interleaved step", seq[k]);
        end
        step();
        read_ok("R12 hold repeats word", 10);
        order_ileave = 0;
    endtask

    task automatic t_prio();
        addr = AW'(8); strobe_cpu_n = 0; strobe_ctl_n = 0;
        wr_all_n = 0; wdata = '1;
        step(); idle_in();
        read_ok("R3 both strobes read", 8);
        ctl_read(8);
        read_ok("R3 no write from processor strobe", 8);
    endtask

    task automatic t_bytes();
        logic [DW-1:0] d = 36'h123456789;
        addr = AW'(12); strobe_ctl_n = 0; wr_byte_en_n = 0;
        lane_sel_n = 4'b1010; wdata = d;
        step(); idle_in();
        for (int i = 0; i < 4; i++)
            if (!lane_sel_n[i] || i == 0 || i == 2) exp_mem[12][i*9 +: 9] = d[i*9 +: 9];
        ctl_read(12);
        read_ok("R8 lanes 0 and 2 written", 12);
        addr = AW'(12); strobe_ctl_n = 0; wr_byte_en_n = 1;
        lane_sel_n = 4'b0000; wdata = '0;
        step(); idle_in();
        ctl_read(12);
        read_ok("R8 no write without lane enable", 12);
        addr = AW'(12); strobe_ctl_n = 0; wr_all_n = 0; wr_byte_en_n = 1;
        lane_sel_n = 4'hF; wdata = 36'hABCDEF012;
        step(); idle_in();
        exp_mem[12] = 36'hABCDEF012;
        ctl_read(12);
        read_ok("R7 full word write", 12);
    endtask

    task automatic t_oe();
        addr = AW'(10); strobe_ctl_n = 0; oe_n = 1;
        step(); strobe_ctl_n = 1;
        check("R9 oe high no drive", {35'd0, rdata_en}, 36'd0);
        check("R9 oe high zero data", rdata, 36'd0);
        oe_n = 0;
        #1;
        read_ok("R9 oe low drives", 10);
        idle_in();
    endtask

    task automatic t_desel();
        addr = AW'(13); strobe_ctl_n = 0; sel3_n = 1; wr_all_n = 0; wdata = '0;
        step(); idle_in();
        check("R4 deselected load no drive", {35'd0, rdata_en}, 36'd0);
        adv_n = 0; step(); idle_in();
        check("R4 enables ignored without load", {35'd0, rdata_en}, 36'd0);
        ctl_read(13);
        check("R10 first read after deselect masked", {35'd0, rdata_en}, 36'd0);
        step();
        read_ok("R10 next read driven, R4 write suppressed", 13);
    endtask

    task automatic t_sleep();
        sleep = 1; addr = AW'(8); strobe_ctl_n = 0; wr_all_n = 0; wdata = '0;
        step();
        check("R11 no drive in sleep", {35'd0, rdata_en}, 36'd0);
        wr_all_n = 1; addr = AW'(9);
        step();
        check("R11 still quiet", {35'd0, rdata_en}, 36'd0);
        idle_in();
        step();
        read_ok("R11 address kept across sleep", 13);
        ctl_read(8);
        read_ok("R11 contents kept", 8);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_linear();
        t_ileave();
        t_prio();
        t_bytes();
        t_oe();
        t_desel();
        t_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule